// File: doc/BRIEF.md
# Relative-Step Program Counter

This block holds the 8-bit instruction pointer of a small accumulator processor. Its private adder forms the next value in one of two ways: it adds one to step to the next code byte, or it adds a signed byte taken from an auxiliary operand register. The relative-add path serves short branches. The sequencer usually steps the counter twice across a two-byte branch instruction and then adds the offset, so the target is the branch's own address plus two plus the offset.

Every update passes through a write strobe. While the strobe is low, the register takes its own value back on each rising edge. The current count drives the code-fetch address bus. That bus is wider than the count, and its upper bits are tied to zero.

Top module: `pcRelUnit`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes 0 after that edge. This holds whatever `writeEn`, `opSel` and `auxVal` are.
- R2: When `writeEn` is 1 and `opSel` is 0 (increment) at a rising edge, `count` becomes the old count plus one, modulo 256.
- R3: When `writeEn` is 1 and `opSel` is 1 (relative add) at a rising edge, `count` becomes the old count plus `auxVal`, modulo 256. `auxVal` is read as a two's-complement offset from -128 to +127.
- R4: When `writeEn` is 0 at a rising edge, `count` keeps its value. In that case `opSel` and `auxVal` have no effect.
- R5: `addr` bits 7..0 always equal `count`, and `addr` bits 14..8 are always zero.
- R6: Incrementing from 255 gives 0.
- R7: A backward relative add that passes below 0 wraps into the top of the range. For example, count 0 plus offset 0xFF (-1) gives 255.
- R8: Two increments followed by a relative add with offset `r`, starting from count `p`, give (p + 2 + r) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| writeEn | input | 1 | Capture the computed next value |
| opSel | input | 1 | 0 = increment, 1 = add auxiliary offset |
| auxVal | input | 8 | Signed offset from the auxiliary register |
| count | output | 8 | Current program count |
| addr | output | 15 | Count zero-extended to the address bus width |

## Verification
The bench keeps the default configuration: an 8-bit count and a 15-bit address. With those widths, every one of the 256 offsets can be applied as a run of 256 chained relative adds. For odd offsets, each run passes through every start value, so wrap in both directions is reached many times. Long increment runs cross the 255-to-0 boundary. Branch-shaped triples and held cycles with scrambled `opSel` and `auxVal` complete the coverage.

// File: rtl/pcUnitPkg.sv
package pcUnitPkg;

  typedef enum logic {
    OP_INC = 1'b0,
    OP_ADD = 1'b1
  } pcOpE;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic clear;    // force count to zero
    logic capture;  // load adder result
    logic addAux;   // adder operand: auxiliary offset instead of one
  } pcStrobeS;

endpackage

// File: rtl/pcCtrl.sv
module pcCtrl
  import pcUnitPkg::*;
(
  input  logic     rst,
  input  logic     writeEn,
  input  logic     opSel,
  output pcStrobeS strobe
);

  pcOpE opKind;

  always_comb begin
    opKind         = pcOpE'(opSel);
    strobe         = '0;
    strobe.clear   = rst;
    strobe.capture = writeEn && !rst;
    strobe.addAux  = (opKind == OP_ADD);
  end

endmodule

// File: rtl/pcDatapath.sv
module pcDatapath
  import pcUnitPkg::*;
#(
  parameter int CountW = 8
) (
  input  logic              clk,
  input  pcStrobeS          strobe,
  input  logic [CountW-1:0] auxVal,
  output logic [CountW-1:0] count
);

  localparam logic [CountW-1:0] StepOne = CountW'(1);

  logic [CountW-1:0] operand;
  logic [CountW-1:0] sumVal;
  logic [CountW-1:0] nextVal;

  // One adder serves both operations; the carry out is dropped so the sum wraps
  always_comb begin
    operand = strobe.addAux ? auxVal : StepOne;
    sumVal  = count + operand;
    if (strobe.clear)        nextVal = '0;
    else if (strobe.capture) nextVal = sumVal;
    else                     nextVal = count;
  end

  always_ff @(posedge clk) begin
    count <= nextVal;
  end

endmodule

// File: rtl/pcRelUnit.sv
module pcRelUnit
  import pcUnitPkg::*;
#(
  parameter int CountW = 8,
  parameter int AddrW  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              writeEn,
  input  logic              opSel,
  input  logic [CountW-1:0] auxVal,
  output logic [CountW-1:0] count,
  output logic [AddrW-1:0]  addr
);

  localparam int PadW = AddrW - CountW;

  pcStrobeS strobe;

  pcCtrl uCtrl (
    .rst     (rst),
    .writeEn (writeEn),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  pcDatapath #(.CountW(CountW)) uPath (
    .clk    (clk),
    .strobe (strobe),
    .auxVal (auxVal),
    .count  (count)
  );

  generate
    if (PadW > 0) begin : gPad
      assign addr = {{PadW{1'b0}}, count};
    end else begin : gTrunc
      assign addr = count[AddrW-1:0];
    end
  endgenerate

endmodule

// File: rtl/pcRelUnitChecker.sv
module pcRelUnitChecker #(
  parameter int CountW = 8,
  parameter int AddrW  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              writeEn,
  input logic              opSel,
  input logic [CountW-1:0] auxVal,
  input logic [CountW-1:0] count,
  input logic [AddrW-1:0]  addr
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (writeEn && !opSel) |=> (count == CountW'($past(count) + CountW'(1))));

  a_r3_rel_add: assert property (@(posedge clk) disable iff (rst)
    (writeEn && opSel) |=> (count == CountW'($past(count) + $past(auxVal))));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !writeEn |=> $stable(count));

  a_r5_addr_low: assert property (@(posedge clk) disable iff (rst)
    addr[CountW-1:0] == count);

  a_r5_addr_pad: assert property (@(posedge clk) disable iff (rst)
    addr[AddrW-1:CountW] == '0);

  a_r6_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (writeEn && !opSel && count == '1) |=> (count == '0));

endmodule

bind pcRelUnit pcRelUnitChecker #(.CountW(CountW), .AddrW(AddrW)) uChk (
  .clk     (clk),
  .rst     (rst),
  .writeEn (writeEn),
  .opSel   (opSel),
  .auxVal  (auxVal),
  .count   (count),
  .addr    (addr)
);

// File: tb/pcRelUnit_test.sv
module pcRelUnit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        writeEn = 1'b0;
  logic        opSel = 1'b0;
  logic [7:0]  auxVal = 8'h00;
  logic [7:0]  count;
  logic [14:0] addr;

  int vecCount = 0;
  int failCount = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  pcRelUnit uut (
    .clk     (clk),
    .rst     (rst),
    .writeEn (writeEn),
    .opSel   (opSel),
    .auxVal  (auxVal),
    .count   (count),
    .addr    (addr)
  );

  task automatic checkNow(input string req, input logic [7:0] exp);
    vecCount++;
    if (count !== exp || addr !== {7'b0, exp}) begin
      failCount++;
      $display("FAIL %s: count=%0h addr=%0h expected count=%0h addr=%0h",
               req, count, addr, exp, {7'b0, exp});
    end
  endtask

  // Drive away from the edge, take one rising edge, sample just after it
  task automatic step(input logic r, input logic we, input logic op,
                      input logic [7:0] a);
    @(negedge clk);
    rst = r; writeEn = we; opSel = op; auxVal = a;
    @(posedge clk);
    #1;
    if (r)       model = 8'h00;
    else if (we) model = op ? 8'(model + a) : 8'(model + 8'd1);
  endtask

  initial begin
    #(4 * 200000);
    failCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    // R1: reset state
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 1'b1, 8'h55);
    checkNow("R1 reset", 8'h00);

    // R2/R6: long increment run crossing 255 -> 0
    for (int i = 0; i < 300; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'(i * 7));
      checkNow(model == 8'h00 ? "R6 wrap at top" : "R2 increment", model);
    end

    // R4: hold with scrambled operation and offset
    for (int i = 0; i < 64; i++) begin
      step(1'b0, 1'b0, i[0], 8'(i * 37 + 3));
      checkNow("R4 hold", model);
    end

    // R7: explicit backward wrap from 0
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b1, 8'hFF);
    checkNow("R7 back wrap 0-1", 8'hFF);
    step(1'b0, 1'b1, 1'b1, 8'h80);
    checkNow("R7 back add -128", 8'h7F);

    // R8: branch-shaped triples for every offset
    for (int r = 0; r < 256; r++) begin
      logic [7:0] base;
      base = model;
      step(1'b0, 1'b1, 1'b0, 8'hAA);
      step(1'b0, 1'b1, 1'b0, 8'h55);
      step(1'b0, 1'b1, 1'b1, 8'(r));
      checkNow("R8 branch target", 8'(base + 8'd2 + 8'(r)));
    end

    // R3/R5/R7: chained relative adds, every offset
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 256; k++) begin
        logic [7:0] prev;
        prev = model;
        step(1'b0, 1'b1, 1'b1, 8'(b));
        if (b >= 128 && model > prev) checkNow("R7 backward wrap", model);
        else                          checkNow("R3 relative add", model);
      end
    end

    // R1: reset overrides a pending write
    step(1'b0, 1'b1, 1'b1, 8'h40);
    step(1'b1, 1'b1, 1'b0, 8'h00);
    checkNow("R1 reset over write", 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule